// File: doc/BRIEF.md
# Multi-Mode Bitmap Pixel Decoder

This block sits between a raster sync generator and a byte-wide video RAM. Each clock it takes the horizontal and vertical raster counters and computes the RAM byte address of the pixel under the beam. It then decodes the returned byte into 4-bit red, green and blue levels. The decoding depends on a mode register. A byte can hold one direct 2-2-2 colour pixel, one index into a built-in 256-entry colour table, or two 4-bit pixels. A 4-bit pixel is resolved either through sixteen CPU-programmable palette registers or onto a sixteen-step grey ramp.

A half-resolution option maps a 320x240 picture onto the 640x480 raster by repeating every source pixel and every source line. A short-frame option limits the active area to 400 raster lines, which gives 320x200 when combined with half resolution. A CPU writes the mode and the palette through a small register port. That port has a chip select, a write enable, a register select and separate write and read data buses.

The decoder is a two-stage pipeline. The first stage registers the address together with the pixel context. The second stage captures the RAM byte one full clock later and registers the colour. Colour for the counter values presented before a clock edge appears after the following edge.

Top module: `pix_decoder`

## Requirements
- R1: After reset, red_o, green_o and blue_o are zero, the mode register reads 0 and all sixteen palette registers read 0.
- R2: A clock edge that sees cs_i=1 and we_i=1 writes cpu_wdata_i into the register chosen by rsel_i. Selects 0 to 15 are the palette entries, select 16 is the mode register (bits 3:0 kept), and selects 17 to 31 are ignored. With cs_i=1 and we_i=0, cpu_rdata_o shows the selected register, with the mode zero-extended and unmapped selects reading 0. With cs_i=0, cpu_rdata_o is 0.
- R3: The colour for counters sampled at edge k is driven after edge k+1. The colour is 0 whenever hcnt_i >= 640 or vcnt_i is at or beyond the active line limit.
- R4: Mode field bits 1:0 = 0 selects direct colour. Byte bits 1:0 give red, bits 3:2 give green and bits 5:4 give blue. Each 2-bit value c is output as {c,c}, and bits 7:6 have no effect.
- R5: Mode field 1 selects table colour. Byte i outputs red {i[7:5],i[7]}, green {i[4:2],i[4]} and blue {i[1:0],i[1:0]}. These come from a 16-bit table entry laid out with red in bits 11:8, green in 7:4 and blue in 3:0.
- R6: Mode field 2 selects palette colour. Each byte holds two pixels: the high nibble is shown at even source columns and the low nibble at odd ones. The nibble selects a palette register, which is decoded with the R4 layout.
- R7: Mode field 3 selects grey. The nibble chosen as in R6 is output on all three channels.
- R8: At full resolution the RAM address is vcnt*640+hcnt for byte-per-pixel modes (fields 0 and 1) and vcnt*320+hcnt/2 for nibble modes (fields 2 and 3).
- R9: Mode bit 2 selects half resolution. The source column is hcnt/2 and the source line is vcnt/2, with 320 bytes per line for byte modes and 160 for nibble modes.
- R10: Mode bit 3 limits the active area to raster lines 0 to 399. Without it, the active area is lines 0 to 479.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hcnt_i | input | 10 | Horizontal raster counter |
| vcnt_i | input | 10 | Vertical raster counter |
| ram_addr_o | output | 19 | Video RAM byte address |
| ram_data_i | input | 8 | Byte returned by video RAM for ram_addr_o |
| cs_i | input | 1 | Register port chip select |
| we_i | input | 1 | Register port write enable (1 = write) |
| rsel_i | input | 5 | Register select |
| cpu_wdata_i | input | 8 | Register write data |
| cpu_rdata_o | output | 8 | Register read data |
| red_o | output | 4 | Red level |
| green_o | output | 4 | Green level |
| blue_o | output | 4 | Blue level |

## Verification
The raster is swept along whole lines, including the right blanking columns. It covers lines on both sides of the 200-, 240-, 400- and 480-line boundaries, in every colour field at both resolutions and with the short frame. The RAM answers with a byte derived arithmetically from the address, so a wrong address, a swapped nibble order or a wrong line pitch each produce a visibly different colour. Palette entries carry different values in their ignored top bits, which separates a correct lookup from a stale or wrongly indexed one. Register reads, including unmapped and deselected ones, show whether stray writes reached the mode or the palette.

// File: rtl/pix_pkg.sv
package pix_pkg;
  typedef enum logic [1:0] {
    FMT_DIRECT = 2'd0,
    FMT_TABLE  = 2'd1,
    FMT_PAL    = 2'd2,
    FMT_GREY   = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [3:0] r;
    logic [3:0] g;
    logic [3:0] b;
  } rgb_t;

  // xxBBGGRR, each 2-bit level widened by repetition
  function automatic rgb_t expand_222(input logic [7:0] d);
    rgb_t c;
    c.r = {d[1:0], d[1:0]};
    c.g = {d[3:2], d[3:2]};
    c.b = {d[5:4], d[5:4]};
    return c;
  endfunction
endpackage

// File: rtl/pix_regs.sv
module pix_regs #(
  parameter int SEL_W = 5,
  parameter int DW    = 8,
  parameter int PAL_N = 16,
  parameter int MW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [MW-1:0]    mode_o,
  output logic [DW-1:0]    pal_o [PAL_N]
);
  localparam int PIDX_W = $clog2(PAL_N);
  localparam logic [SEL_W-1:0] MODE_SEL = SEL_W'(PAL_N);

  logic wr_en;
  assign wr_en = cs_i && we_i;

  for (genvar gi = 0; gi < PAL_N; gi++) begin : g_pal
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            pal_o[gi] <= '0;
      else if (wr_en && sel_i == SEL_W'(gi))  pal_o[gi] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        mode_o <= '0;
    else if (wr_en && sel_i == MODE_SEL) mode_o <= wdata_i[MW-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (cs_i && !we_i) begin
      if (sel_i < MODE_SEL)       rdata_o = pal_o[sel_i[PIDX_W-1:0]];
      else if (sel_i == MODE_SEL) rdata_o = DW'(mode_o);
    end
  end

  assert_mode_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && sel_i == MODE_SEL) |=> (mode_o == $past(wdata_i[MW-1:0])));

  assert_unmapped_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && sel_i > MODE_SEL) |=> $stable(mode_o));
endmodule

// File: rtl/pix_addr_gen.sv
module pix_addr_gen
  import pix_pkg::*;
#(
  parameter int H_ACT   = 640,
  parameter int V_ACT   = 480,
  parameter int V_SHORT = 400,
  parameter int CNT_W   = 10,
  parameter int ADDR_W  = 19,
  parameter int MW      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  hcnt_i,
  input  logic [CNT_W-1:0]  vcnt_i,
  input  logic [MW-1:0]     mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              act_o,
  output logic              lo_nib_o,
  output fmt_e              fmt_o
);
  localparam logic [CNT_W-1:0]  H_LIM   = CNT_W'(H_ACT);
  localparam logic [CNT_W-1:0]  V_LIM   = CNT_W'(V_ACT);
  localparam logic [CNT_W-1:0]  V_LIM_S = CNT_W'(V_SHORT);
  localparam logic [ADDR_W-1:0] BPL_F8  = ADDR_W'(H_ACT);
  localparam logic [ADDR_W-1:0] BPL_F4  = ADDR_W'(H_ACT / 2);
  localparam logic [ADDR_W-1:0] BPL_H8  = ADDR_W'(H_ACT / 2);
  localparam logic [ADDR_W-1:0] BPL_H4  = ADDR_W'(H_ACT / 4);

  logic              half, nib_mode;
  logic [CNT_W-1:0]  px, py, col;
  logic [ADDR_W-1:0] bpl, addr_n;
  logic              act_n;

  assign half     = mode_i[2];
  assign nib_mode = mode_i[1];

  always_comb begin
    px  = half ? (hcnt_i >> 1) : hcnt_i;
    py  = half ? (vcnt_i >> 1) : vcnt_i;
    col = nib_mode ? (px >> 1) : px;
    unique case ({half, nib_mode})
      2'b00:   bpl = BPL_F8;
      2'b01:   bpl = BPL_F4;
      2'b10:   bpl = BPL_H8;
      default: bpl = BPL_H4;
    endcase
    addr_n = ADDR_W'(py) * bpl + ADDR_W'(col);
    act_n  = (hcnt_i < H_LIM) && (vcnt_i < (mode_i[3] ? V_LIM_S : V_LIM));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      act_o    <= 1'b0;
      lo_nib_o <= 1'b0;
      fmt_o    <= FMT_DIRECT;
    end else begin
      addr_o   <= addr_n;
      act_o    <= act_n;
      lo_nib_o <= px[0];
      fmt_o    <= fmt_e'(mode_i[1:0]);
    end
  end

  assert_full_byte_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2:1] == 2'b00 && hcnt_i < H_LIM && vcnt_i < V_LIM)
    |=> (int'(addr_o) == int'($past(vcnt_i)) * H_ACT + int'($past(hcnt_i))));

  assert_half_nib_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2:1] == 2'b11 && hcnt_i < H_LIM && vcnt_i < V_LIM)
    |=> (int'(addr_o) == (int'($past(vcnt_i)) / 2) * (H_ACT / 4) + int'($past(hcnt_i)) / 4));
endmodule

// File: rtl/pix_lut256.sv
module pix_lut256
  import pix_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int ENT_W = 16
) (
  input  logic [IDX_W-1:0] idx_i,
  output rgb_t             rgb_o
);
  localparam int N = 1 << IDX_W;

  function automatic logic [ENT_W-1:0] entry(input logic [7:0] i);
    return ENT_W'({i[7:5], i[7], i[4:2], i[4], i[1:0], i[1:0]});
  endfunction

  logic [ENT_W-1:0] rom [N];
  logic [ENT_W-1:0] ent;
  logic             unused_hi;

  for (genvar gi = 0; gi < N; gi++) begin : g_rom
    assign rom[gi] = entry(8'(gi));
  end

  assign ent       = rom[idx_i];
  assign rgb_o     = ent[11:0];
  assign unused_hi = ^ent[ENT_W-1:12];
endmodule

// File: rtl/pix_color.sv
module pix_color
  import pix_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PAL_N = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  fmt_e          fmt_i,
  input  logic          lo_nib_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] pal_i [PAL_N],
  output rgb_t          rgb_o
);
  localparam int NIB_W = $clog2(PAL_N);

  logic [NIB_W-1:0] nib;
  rgb_t             tbl_c, c;

  pix_lut256 #(.IDX_W(DW), .ENT_W(16)) u_lut (
    .idx_i (data_i),
    .rgb_o (tbl_c)
  );

  always_comb begin
    nib = lo_nib_i ? data_i[NIB_W-1:0] : data_i[DW-1:DW-NIB_W];
    unique case (fmt_i)
      FMT_DIRECT: c = expand_222(data_i);
      FMT_TABLE:  c = tbl_c;
      FMT_PAL:    c = expand_222(pal_i[nib]);
      default:    c = '{r: nib, g: nib, b: nib};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rgb_o <= '0;
    else if (act_i) rgb_o <= c;
    else            rgb_o <= '0;
  end

  assert_grey_equal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && fmt_i == FMT_GREY) |=> (rgb_o.r == rgb_o.g && rgb_o.g == rgb_o.b));

  assert_direct_red_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && fmt_i == FMT_DIRECT) |=> (rgb_o.r[1:0] == $past(data_i[1:0])));
endmodule

// File: rtl/pix_decoder.sv
module pix_decoder
  import pix_pkg::*;
#(
  parameter int H_ACT   = 640,
  parameter int V_ACT   = 480,
  parameter int V_SHORT = 400,
  parameter int CNT_W   = 10,
  parameter int ADDR_W  = $clog2(H_ACT * V_ACT),
  parameter int DW      = 8,
  parameter int SEL_W   = 5,
  parameter int PAL_N   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  hcnt_i,
  input  logic [CNT_W-1:0]  vcnt_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [DW-1:0]     ram_data_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  rsel_i,
  input  logic [DW-1:0]     cpu_wdata_i,
  output logic [DW-1:0]     cpu_rdata_o,
  output logic [3:0]        red_o,
  output logic [3:0]        green_o,
  output logic [3:0]        blue_o
);
  localparam int MW = 4;
  localparam logic [CNT_W-1:0] H_LIM = CNT_W'(H_ACT);

  logic [MW-1:0] mode;
  logic [DW-1:0] pal [PAL_N];
  logic          act_q, lo_q;
  fmt_e          fmt_q;
  rgb_t          rgb;

  pix_regs #(.SEL_W(SEL_W), .DW(DW), .PAL_N(PAL_N), .MW(MW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_i    (cs_i),
    .we_i    (we_i),
    .sel_i   (rsel_i),
    .wdata_i (cpu_wdata_i),
    .rdata_o (cpu_rdata_o),
    .mode_o  (mode),
    .pal_o   (pal)
  );

  pix_addr_gen #(.H_ACT(H_ACT), .V_ACT(V_ACT), .V_SHORT(V_SHORT),
                 .CNT_W(CNT_W), .ADDR_W(ADDR_W), .MW(MW)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hcnt_i   (hcnt_i),
    .vcnt_i   (vcnt_i),
    .mode_i   (mode),
    .addr_o   (ram_addr_o),
    .act_o    (act_q),
    .lo_nib_o (lo_q),
    .fmt_o    (fmt_q)
  );

  pix_color #(.DW(DW), .PAL_N(PAL_N)) u_color (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (act_q),
    .fmt_i    (fmt_q),
    .lo_nib_i (lo_q),
    .data_i   (ram_data_i),
    .pal_i    (pal),
    .rgb_o    (rgb)
  );

  assign red_o   = rgb.r;
  assign green_o = rgb.g;
  assign blue_o  = rgb.b;

  // edges seen since reset, for two-deep history checks
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assert_blank_right_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2 && $past(hcnt_i, 2) >= H_LIM) |-> (red_o == '0 && green_o == '0 && blue_o == '0));
endmodule

// File: tb/pix_decoder_test.sv
module pix_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  hcnt = '0, vcnt = '0;
  logic [18:0] ram_addr;
  logic [7:0]  ram_data;
  logic        cs = 1'b0, we = 1'b0;
  logic [4:0]  rsel = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  red, green, blue;

  int total = 0, bad = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pix_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .hcnt_i(hcnt), .vcnt_i(vcnt),
    .ram_addr_o(ram_addr), .ram_data_i(ram_data),
    .cs_i(cs), .we_i(we), .rsel_i(rsel), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .red_o(red), .green_o(green), .blue_o(blue)
  );

  function automatic logic [7:0] ram_fn(input int a);
    return 8'((a * 29 + (a >> 7) * 3 + 5) & 255);
  endfunction
  assign ram_data = ram_fn(int'(ram_addr));

  // behavioural reference
  int    m_mode = 0;
  int    m_pal [16];
  int    pend [$];
  logic [11:0] exp_rgb = '0;
  string exp_tag = "R1";

  function automatic logic [11:0] ref_px(input int h, input int v, input int m, output string tag);
    int half, shrt, fmt, vl, px, py, w, addr, b, nib, r, g, bl, p;
    string base;
    half = (m >> 2) & 1; shrt = (m >> 3) & 1; fmt = m & 3;
    vl = shrt ? 400 : 480;
    if (h >= 640 || v >= vl) begin
      tag = shrt ? "R3 R10" : "R3";
      return 12'h000;
    end
    px = half ? h / 2 : h;
    py = half ? v / 2 : v;
    w  = half ? 320 : 640;
    addr = (fmt >= 2) ? py * (w / 2) + px / 2 : py * w + px;
    b   = int'(ram_fn(addr));
    nib = (px % 2 == 0) ? (b >> 4) : (b & 15);
    case (fmt)
      0: begin r = (b & 3) * 5; g = ((b >> 2) & 3) * 5; bl = ((b >> 4) & 3) * 5; base = "R4"; end
      1: begin
        r = ((b >> 5) & 7) * 2 + ((b >> 7) & 1);
        g = ((b >> 2) & 7) * 2 + ((b >> 4) & 1);
        bl = (b & 3) * 5; base = "R5";
      end
      2: begin
        p = m_pal[nib];
        r = (p & 3) * 5; g = ((p >> 2) & 3) * 5; bl = ((p >> 4) & 3) * 5; base = "R6";
      end
      default: begin r = nib; g = nib; bl = nib; base = "R7"; end
    endcase
    tag = $sformatf("%s R8%s%s", base, half ? " R9" : "", shrt ? " R10" : "");
    return {4'(r), 4'(g), 4'(bl)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pend.delete();
      m_mode = 0;
      foreach (m_pal[i]) m_pal[i] = 0;
      exp_rgb = '0; exp_tag = "R1";
    end else begin
      if (pend.size() > 0) begin
        int e;
        e = pend.pop_front();
        exp_rgb = ref_px(e & 1023, (e >> 10) & 1023, (e >> 20) & 15, exp_tag);
      end else begin
        exp_rgb = '0; exp_tag = "R1";
      end
      pend.push_back(int'(hcnt) | (int'(vcnt) << 10) | (m_mode << 20));
      if (cs && we) begin
        if (rsel < 16) m_pal[rsel] = int'(wdata);
        else if (rsel == 16) m_mode = int'(wdata) & 15;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      total++;
      if ({red, green, blue} !== exp_rgb) begin
        bad++;
        $display("FAIL %s h/v pipeline: got %h expected %h", exp_tag, {red, green, blue}, exp_rgb);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic reg_wr(input int sel, input int d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; rsel = 5'(sel); wdata = 8'(d);
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(input int sel, input int expv, input string tag);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; rsel = 5'(sel);
    #2;
    chk(tag, int'(rdata), expv);
    cs = 1'b0;
  endtask

  task automatic scan(input int mode);
    int lines [12] = '{0, 1, 2, 199, 239, 240, 398, 399, 400, 479, 480, 500};
    reg_wr(16, mode | 8'hA0);
    reg_rd(16, mode, "R2 mode readback");
    foreach (lines[li]) begin
      for (int h = 0; h < 660; h++) begin
        @(negedge clk);
        hcnt = 10'(h); vcnt = 10'(lines[li]);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rgb in reset", int'({red, green, blue}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rgb after reset", int'({red, green, blue}), 0);
    reg_rd(16, 0, "R1 mode after reset");
    for (int i = 0; i < 16; i++) reg_rd(i, 0, "R1 palette after reset");
    cmp_en = 1'b1;

    for (int i = 0; i < 16; i++) reg_wr(i, ((i * 13 + 7) & 63) | ((i & 3) << 6));
    for (int i = 0; i < 16; i++) reg_rd(i, ((i * 13 + 7) & 63) | ((i & 3) << 6), "R2 palette readback");
    reg_wr(16, 5);
    reg_wr(20, 9);
    reg_wr(31, 15);
    reg_rd(16, 5, "R2 unmapped write ignored");
    reg_rd(20, 0, "R2 unmapped read");
    @(negedge clk);
    cs = 1'b0; we = 1'b0; rsel = 5'd3;
    #2 chk("R2 deselected read", int'(rdata), 0);

    for (int m = 0; m < 8; m++) scan(m);
    scan(8 | 4 | 0);
    scan(8 | 4 | 2);

    repeat (4) @(negedge clk);
    cmp_en = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule